// File: doc/BRIEF.md
# SPI Register-Access Bridge

This block is an SPI target (mode 0, 8-bit words) that converts serial frames into single 32-bit register reads and writes. Every frame opens with a 24-bit command field, always sent most significant bit first. Its top bit selects write (1) or read (0), and the remaining 23 bits give a word address, which is the byte address divided by four. A write frame then carries 32 payload bits. A read frame first carries a programmable number of padding bytes and then shifts out 32 data bits. The padding gives a slow internal target time to respond.

Two words are local to the bridge. Word 0 selects how the 32-bit payload is laid out on the wire, by byte order and by bit order. Word 1 holds the padding count, a sticky flag, and a fixed interface code of 2. The flag records that read data was due on the wire before the target had answered. Every other word address goes to a latency-modelling register stub. All SPI pins are sampled by the system clock through two-stage synchronisers. A reset restores the default layout and a padding count of zero, so the host has to program both again after each reset.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset, word 1 reads 0x0200_0000 and word 0 reads 0, with a padding count of 0 and a layout code of 0.
- R2: The 24-bit command is taken MSB first. Bit 23 = 1 means write and 0 means read. Bits 22:0 are the word address. Word 0 is the layout register, word 1 is the status register, and word addresses from 2 upward reach the stub at index address[log2(depth)-1:0].
- R3: A write is committed only after all 32 payload bits have been received. If chip select rises earlier, the frame is dropped and nothing changes.
- R4: On a read, N = word1[3:0] whole padding bytes follow the command, and then 32 data bits are shifted out on MISO, each launched after an SCK falling edge. N = 0 is allowed.
- R5: Layout code bit 0 selects byte order: 0 puts payload bits 7:0 in the first byte, and 1 puts bits 31:24 first. Bit 1 selects bit order within each byte: 0 sends MSB first, and 1 sends LSB first. The layout code applies to payload in both directions. The command field is never reordered.
- R6: A write to word 0 is decoded with the layout currently in force, and bits 1:0 become the new code. If the host writes code m as the byte {m[0],m[1],0000,m[1],m[0]} in all four bytes, the result is m under any prior layout. Word 0 reads back as this same four-byte pattern.
- R7: Word 1 reads back as follows: bits 3:0 are the padding count, bit 16 is the flag, bits 31:24 are 0x02, and all other bits are 0.
- R8: A stub read answers STUB_LAT clock cycles after its request. If the answer is not ready when the first data bit is launched, the bridge shifts out 32 zero bits and sets the flag.
- R9: The flag stays set until reset or until a word-1 write with bit 16 = 1. A word-1 write with bit 16 = 0 leaves the flag set.
- R10: If the stub answers in the same clock cycle as the data launch, the read counts as in time: the data is correct and the flag is not set.
- R11: MISO is 0 while chip select is high and throughout the command and padding bits.
- R12: Reset at any point returns the layout code and the padding count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
The two events that can fall in the same clock cycle are the stub's answer and the launch of the first data bit. The stub answers a fixed number of cycles after the request is issued on the final command bit. The launch comes a fixed number of SCK half periods later, so the bench sets the stub latency so that one half-period value makes the two events coincide exactly. It then sweeps the half period through the values below, at, and above that point. At each value it checks both the returned data and the status flag: zeros with the flag set below the point, and correct data with the flag clear at and above it.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    FS_CMD,
    FS_PAD,
    FS_WDATA,
    FS_LAUNCH,
    FS_RDATA,
    FS_DONE
  } frame_st_e;

  localparam logic [7:0] IF_CODE_SERIAL = 8'h02;

  // Map a register value onto wire order (bit 31 of the result leaves first).
  // Byte swap and per-byte reversal are both self-inverse, so the same
  // function decodes a received wire word.
  function automatic logic [31:0] wire_order(input logic [31:0] v,
                                             input logic [1:0]  ord);
    logic [31:0] w;
    logic [7:0]  b;
    w = '0;
    for (int j = 0; j < 4; j++) begin
      b = ord[0] ? v[8*(3-j) +: 8] : v[8*j +: 8];
      for (int i = 0; i < 8; i++) begin
        w[31-8*j-i] = ord[1] ? b[i] : b[7-i];
      end
    end
    return w;
  endfunction

  // Layout code mirrored so bits 1:0 survive any byte or bit reordering.
  function automatic logic [31:0] layout_pattern(input logic [1:0] m);
    return {4{m[0], m[1], 4'b0000, m[1], m[0]}};
  endfunction

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int              W    = 1,
  parameter logic [W-1:0]    INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/bridge_cfg.sv
module bridge_cfg
  import bridge_pkg::*;
#(
  parameter int PADW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,      // 0: layout word, 1: status word
  input  logic [31:0]     wr_data,
  input  logic            late_set,
  output logic [1:0]      ord,
  output logic [PADW-1:0] pad,
  output logic [31:0]     layout_word,
  output logic [31:0]     status_word
);
  logic [1:0]      ord_q, ord_n;
  logic [PADW-1:0] pad_q, pad_n;
  logic            flag_q, flag_n;
  logic            clr_req;

  assign clr_req = wr_en && wr_sel && wr_data[16];

  always_comb begin
    ord_n  = ord_q;
    pad_n  = pad_q;
    flag_n = flag_q;
    if (wr_en && !wr_sel) ord_n = wr_data[1:0];
    if (wr_en && wr_sel)  pad_n = wr_data[PADW-1:0];
    if (clr_req)          flag_n = 1'b0;
    if (late_set)         flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q  <= 2'b00;
      pad_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ord_q  <= ord_n;
      pad_q  <= pad_n;
      flag_q <= flag_n;
    end
  end

  always_comb begin
    status_word              = '0;
    status_word[31:24]       = IF_CODE_SERIAL;
    status_word[16]          = flag_q;
    status_word[PADW-1:0]    = pad_q;
  end

  assign layout_word = layout_pattern(ord_q);
  assign ord         = ord_q;
  assign pad         = pad_q;

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);

  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(late_set));
endmodule

// File: rtl/bridge_stub.sv
module bridge_stub #(
  parameter int DEPTH = 16,
  parameter int LAT   = 200,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic          ack,
  output logic [31:0]   rdata
);
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [31:0]     mem_q [DEPTH];

  always_comb begin
    cnt_n = cnt_q;
    if (rd_req)               cnt_n = CNTW'(LAT);
    else if (cnt_q != '0)     cnt_n = cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (wr_req) begin
      mem_q[idx] <= wdata;
    end
  end

  assign ack   = (cnt_q == CNTW'(1)) && !rd_req;
  assign rdata = mem_q[idx];

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

// File: rtl/bridge_frame.sv
module bridge_frame
  import bridge_pkg::*;
#(
  parameter int PADW = 4,
  localparam int CW  = (PADW + 3 > 6) ? PADW + 3 : 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_act,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            mosi_bit,
  input  logic [1:0]      ord,
  input  logic [PADW-1:0] pad,
  input  logic [31:0]     layout_word,
  input  logic [31:0]     status_word,
  input  logic            stub_ack,
  input  logic [31:0]     stub_rdata,
  output logic            miso,
  output logic            rd_req,
  output logic            wr_stb,
  output logic [22:0]     addr,
  output logic [31:0]     wr_data,
  output logic            late
);
  frame_st_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [31:0]   sh_q, sh_n, tx_q, tx_n, rdat_q, rdat_n, wdat_q, wdat_n;
  logic [22:0]   addr_q, addr_n;
  logic          miso_q, miso_n, rdy_q, rdy_n;
  logic          rreq_q, rreq_n, wr_q, wr_n, late_q, late_n;

  logic [23:0]   cmd_word;
  logic [31:0]   pay_word, launch_word;
  logic [CW-1:0] pad_last;
  logic          ready_now, cmd_local;

  assign cmd_word    = {sh_q[22:0], mosi_bit};
  assign pay_word    = {sh_q[30:0], mosi_bit};
  assign pad_last    = CW'({pad, 3'b000}) - CW'(1);
  assign cmd_local   = (cmd_word[22:1] == '0);
  assign ready_now   = rdy_q || stub_ack;
  assign launch_word = wire_order(rdy_q    ? rdat_q     :
                                  stub_ack ? stub_rdata : 32'h0, ord);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    tx_n   = tx_q;
    rdat_n = rdat_q;
    wdat_n = wdat_q;
    addr_n = addr_q;
    miso_n = miso_q;
    rdy_n  = rdy_q;
    rreq_n = 1'b0;
    wr_n   = 1'b0;
    late_n = 1'b0;

    if (stub_ack) begin
      rdy_n  = 1'b1;
      rdat_n = stub_rdata;
    end

    if (!cs_act) begin
      st_n   = FS_CMD;
      cnt_n  = '0;
      miso_n = 1'b0;
    end else if (sck_rise) begin
      unique case (st_q)
        FS_CMD: begin
          sh_n  = pay_word;
          cnt_n = cnt_q + CW'(1);
          if (cnt_q == CW'(23)) begin
            cnt_n  = '0;
            addr_n = cmd_word[22:0];
            if (cmd_word[23]) begin
              st_n = FS_WDATA;
            end else begin
              rreq_n = !cmd_local;
              rdy_n  = cmd_local;
              rdat_n = cmd_word[0] ? status_word : layout_word;
              st_n   = (pad == '0) ? FS_LAUNCH : FS_PAD;
            end
          end
        end
        FS_PAD: begin
          cnt_n = cnt_q + CW'(1);
          if (cnt_q == pad_last) begin
            cnt_n = '0;
            st_n  = FS_LAUNCH;
          end
        end
        FS_WDATA: begin
          sh_n  = pay_word;
          cnt_n = cnt_q + CW'(1);
          if (cnt_q == CW'(31)) begin
            wr_n   = 1'b1;
            wdat_n = wire_order(pay_word, ord);
            st_n   = FS_DONE;
          end
        end
        FS_RDATA: begin
          cnt_n = cnt_q + CW'(1);
          if (cnt_q == CW'(31)) st_n = FS_DONE;
        end
        default: ;
      endcase
    end else if (sck_fall) begin
      unique case (st_q)
        FS_LAUNCH: begin
          miso_n = launch_word[31];
          tx_n   = {launch_word[30:0], 1'b0};
          late_n = !ready_now;
          cnt_n  = '0;
          st_n   = FS_RDATA;
        end
        FS_RDATA: begin
          miso_n = tx_q[31];
          tx_n   = {tx_q[30:0], 1'b0};
        end
        default: miso_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_CMD;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      rdat_q <= '0;
      wdat_q <= '0;
      addr_q <= '0;
      miso_q <= 1'b0;
      rdy_q  <= 1'b0;
      rreq_q <= 1'b0;
      wr_q   <= 1'b0;
      late_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      tx_q   <= tx_n;
      rdat_q <= rdat_n;
      wdat_q <= wdat_n;
      addr_q <= addr_n;
      miso_q <= miso_n;
      rdy_q  <= rdy_n;
      rreq_q <= rreq_n;
      wr_q   <= wr_n;
      late_q <= late_n;
    end
  end

  assign miso    = miso_q;
  assign rd_req  = rreq_q;
  assign wr_stb  = wr_q;
  assign addr    = addr_q;
  assign wr_data = wdat_q;
  assign late    = late_q;

  // R3
  commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_q);

  // R8
  late_at_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_q |-> st_q == FS_RDATA);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> !rreq_q);
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge #(
  parameter int STUB_DEPTH = 16,
  parameter int STUB_LAT   = 200,
  parameter int PAD_W      = 4,
  localparam int IW        = $clog2(STUB_DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [2:0] pins_s;
  logic       sck_s, cs_s, mosi_s, sck_d_q;

  bridge_sync #(.W(3), .INIT(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({spi_sck, spi_cs_n, spi_mosi}),
    .q     (pins_s)
  );
  assign {sck_s, cs_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sck_d_q <= 1'b0;
    else             sck_d_q <= sck_s;
  end

  logic             rd_req, wr_stb, stub_ack, late;
  logic [22:0]      addr;
  logic [31:0]      wr_data, stub_rdata, layout_word, status_word;
  logic [1:0]       ord;
  logic [PAD_W-1:0] pad;
  logic             is_local;

  assign is_local = (addr[22:1] == '0);

  bridge_frame #(.PADW(PAD_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cs_act      (!cs_s),
    .sck_rise    (sck_s && !sck_d_q),
    .sck_fall    (!sck_s && sck_d_q),
    .mosi_bit    (mosi_s),
    .ord         (ord),
    .pad         (pad),
    .layout_word (layout_word),
    .status_word (status_word),
    .stub_ack    (stub_ack),
    .stub_rdata  (stub_rdata),
    .miso        (spi_miso),
    .rd_req      (rd_req),
    .wr_stb      (wr_stb),
    .addr        (addr),
    .wr_data     (wr_data),
    .late        (late)
  );

  bridge_cfg #(.PADW(PAD_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_stb && is_local),
    .wr_sel      (addr[0]),
    .wr_data     (wr_data),
    .late_set    (late),
    .ord         (ord),
    .pad         (pad),
    .layout_word (layout_word),
    .status_word (status_word)
  );

  bridge_stub #(.DEPTH(STUB_DEPTH), .LAT(STUB_LAT)) u_stub (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_req (rd_req),
    .wr_req (wr_stb && !is_local),
    .idx    (addr[IW-1:0]),
    .wdata  (wr_data),
    .ack    (stub_ack),
    .rdata  (stub_rdata)
  );
endmodule

// File: tb/spi_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module spi_reg_bridge_tb_top;
  localparam int LAT = 203;

  logic clk, rst_n, sck, cs_n, mosi, miso;
  int   n_chk = 0, n_fail = 0, hp = 8;
  logic [1:0] m_ord = 2'b00;
  int   m_pad = 0;
  bit   last_pre = 0;
  bit   done = 0;

  spi_reg_bridge #(.STUB_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] tb_wire(input logic [31:0] v, input logic [1:0] o);
    logic [31:0] w;
    for (int k = 0; k < 32; k++) begin
      int sb = o[0] ? 3 - k / 8 : k / 8;
      int bi = o[1] ? k % 8 : 7 - k % 8;
      w[31-k] = v[8*sb + bi];
    end
    return w;
  endfunction

  function automatic logic [31:0] pat(input logic [1:0] m);
    logic [7:0] b;
    b = {m[0], m[1], 4'b0000, m[1], m[0]};
    return {b, b, b, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [23:0] cmd, input int npad, input logic [31:0] wout,
                       input bit is_rd, input int ndata, output logic [31:0] win);
    int hdr;
    hdr = 24 + npad * 8;
    win = '0;
    last_pre = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (hp) @(negedge clk);
    for (int k = 0; k < hdr + ndata; k++) begin
      if (k < 24)        mosi = cmd[23-k];
      else if (k < hdr)  mosi = 1'b0;
      else               mosi = is_rd ? 1'b0 : wout[31-(k-hdr)];
      repeat (hp) @(negedge clk);
      sck = 1'b1;
      if (k >= hdr) win[31-(k-hdr)] = miso;
      else if (miso !== 1'b0) last_pre = 1;
      repeat (hp) @(negedge clk);
      sck = 1'b0;
    end
    repeat (hp) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * hp) @(negedge clk);
  endtask

  task automatic wr(input logic [22:0] a, input logic [31:0] v);
    logic [31:0] w;
    frame({1'b1, a}, 0, tb_wire(v, m_ord), 1'b0, 32, w);
  endtask

  task automatic rd(input logic [22:0] a, output logic [31:0] v);
    logic [31:0] w;
    frame({1'b0, a}, m_pad, 32'h0, 1'b1, 32, w);
    v = tb_wire(w, m_ord);
  endtask

  task automatic set_ord(input logic [1:0] o);
    wr(23'd0, pat(o));
    m_ord = o;
  endtask

  task automatic set_cfg(input logic [31:0] v);
    wr(23'd1, v);
    m_pad = int'(v[3:0]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    m_ord = 2'b00;
    m_pad = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R11 miso with cs high", {31'b0, miso}, 32'h0);
    rd(23'd1, v);
    chk("R1 R7 status after reset", v, 32'h0200_0000);
    chk("R11 miso in command", {31'b0, last_pre}, 32'h0);
    rd(23'd0, v);
    chk("R1 layout after reset", v, 32'h0);
  endtask

  task automatic t_layouts();
    logic [31:0] v, raw;
    set_cfg(32'h2);
    set_ord(2'b01);
    wr(23'd2, 32'h1234_5678);
    for (int o = 0; o < 4; o++) begin
      set_ord(2'(o));
      rd(23'd0, v);
      chk("R6 layout readback", v, pat(2'(o)));
      rd(23'd2, v);
      chk("R5 read in layout", v, 32'h1234_5678);
      raw = tb_wire(v, 2'(o));
      chk("R5 wire image", tb_wire(raw, 2'(o)), 32'h1234_5678);
      wr(23'(4 + o), 32'hA1B2_C3D4 ^ 32'(o));
    end
    set_ord(2'b01);
    for (int o = 0; o < 4; o++) begin
      rd(23'(4 + o), v);
      chk("R5 cross-layout store", v, 32'hA1B2_C3D4 ^ 32'(o));
    end
    set_ord(2'b10);
    rd(23'd2, v);
    chk("R5 LE LSB-first read", v, 32'h1234_5678);
  endtask

  task automatic t_addr_pad();
    logic [31:0] v;
    wr(23'd3, 32'hDEAD_0003);
    rd(23'd3, v);
    chk("R2 word 3", v, 32'hDEAD_0003);
    rd(23'd1, v);
    chk("R7 status pad2", v, 32'h0200_0002);
    set_cfg(32'h3);
    rd(23'd2, v);
    chk("R4 pad3 read", v, 32'h1234_5678);
    chk("R11 miso in padding", {31'b0, last_pre}, 32'h0);
    set_cfg(32'h0);
    rd(23'd0, v);
    chk("R4 pad0 local read", v, pat(m_ord));
    set_cfg(32'h2);
  endtask

  task automatic t_late();
    logic [31:0] v;
    set_cfg(32'h1);
    rd(23'd2, v);
    chk("R8 late read zeros", v, 32'h0);
    rd(23'd1, v);
    chk("R8 flag set", v, 32'h0201_0001);
    set_cfg(32'h0000_0001);
    rd(23'd1, v);
    chk("R9 flag sticky", v, 32'h0201_0001);
    set_cfg(32'h0001_0002);
    rd(23'd1, v);
    chk("R9 flag cleared", v, 32'h0200_0002);
  endtask

  task automatic t_abort();
    logic [31:0] w, v;
    frame({1'b1, 23'd2}, 0, tb_wire(32'hFFFF_0000, m_ord), 1'b0, 20, w);
    rd(23'd2, v);
    chk("R3 aborted write", v, 32'h1234_5678);
  endtask

  task automatic t_boundary();
    logic [31:0] v;
    set_cfg(32'h1);
    for (int h = 11; h <= 13; h++) begin
      bit ok;
      hp = h;
      ok = (17 * h >= LAT + 1);
      rd(23'd2, v);
      hp = 8;
      chk("R10 boundary data", v, ok ? 32'h1234_5678 : 32'h0);
      rd(23'd1, v);
      chk("R10 boundary flag", v, ok ? 32'h0200_0001 : 32'h0201_0001);
      set_cfg(32'h0001_0001);
    end
    set_cfg(32'h2);
  endtask

  task automatic t_rst_again();
    logic [31:0] v;
    set_ord(2'b11);
    set_cfg(32'h3);
    do_reset();
    rd(23'd1, v);
    chk("R12 status after reset", v, 32'h0200_0000);
    rd(23'd0, v);
    chk("R12 layout after reset", v, 32'h0);
  endtask

  initial begin
    sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    do_reset();
    t_reset();
    t_layouts();
    t_addr_pad();
    t_late();
    t_abort();
    t_boundary();
    t_rst_again();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule